// File: doc/BRIEF.md
# Multi-tap variable sample delay

This block delays a single stream of signed audio samples and produces several delayed copies of it at once. Each output tap has its own delay control, an integer count of whole samples that may change with every sample. All taps read from one shared circular buffer. The buffer's depth is the largest delay plus one, and it is fixed by a build parameter. Changing the largest delay means rebuilding the block.

On each sample strobe the block stores the incoming sample. It also captures every tap's control word, clamped into the legal range. It then reads the taps out one per clock cycle. When all tap outputs are updated, it raises a single-cycle valid strobe. A tap asks for the sample that arrived its delay count of strobes earlier. A delay of zero returns the sample written by the same strobe. Buffer positions that have not been written since reset read as zero.

Strobes must be spaced at least `NUM_TAPS + 1` cycles apart. A strobe that arrives while the taps are still being read out is not taken.

Top module: `vdl_multitap`

## Requirements
- R1: For a control value d with 0 <= d <= MAX_DELAY, a tap outputs the sample that was presented d accepted strobes before the current one.
- R2: A delay of 0 returns the sample presented with the current strobe.
- R3: A delay of MAX_DELAY returns the sample presented exactly MAX_DELAY strobes earlier, including after the write pointer has wrapped around the buffer.
- R4: Each control word is a two's complement integer (CTRL_W bits, no fraction bits). A negative value acts as 0, and a value above MAX_DELAY acts as MAX_DELAY.
- R5: The taps are independent. Tap k takes its control from `tap_delay_i[k*CTRL_W +: CTRL_W]` and drives `tap_sample_o[k*DATA_W +: DATA_W]`.
- R6: A tap whose delay reaches back past the first sample written since reset outputs 0.
- R7: `tap_valid_o` is high for exactly one cycle. It rises on the NUM_TAPS-th rising edge after the edge that samples an accepted `sample_valid_i`.
- R8: After reset all tap outputs are 0 and `tap_valid_o` is 0. Tap outputs keep their value between readouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe; stores `sample_i` and starts a readout |
| sample_i | input | DATA_W | Signed audio sample |
| tap_delay_i | input | NUM_TAPS*CTRL_W | Per-tap delay controls, signed integers |
| tap_sample_o | output | NUM_TAPS*DATA_W | Per-tap delayed samples |
| tap_valid_o | output | 1 | One-cycle strobe when all taps are updated |

## Verification
Several control patterns are used, and each one isolates a different fault:
- Constant delays over a ramp of samples longer than the buffer expose wrong pointer arithmetic and wrong wrap handling at the top of the range.
- Zero and full-range delays at the very start separate the bypass path from the not-yet-written zero fill.
- Out-of-range controls (large positive, most negative, just past the limit) check the clamp on both sides.
- Per-sample sweeps in opposite directions on different taps, followed by random signed samples with random controls, show whether taps swap lanes or take a control from the wrong strobe.

// File: rtl/vdl_pkg.sv
package vdl_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // index width that stays legal for a count of one
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/vdl_clamp.sv
module vdl_clamp #(
  parameter int CTRL_W    = 28,
  parameter int MAX_DELAY = 480,
  parameter int DLY_W     = 9
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [DLY_W-1:0]  dly_o
);

  localparam logic [CTRL_W-1:0] MaxCtrl = CTRL_W'(MAX_DELAY);
  localparam logic [DLY_W-1:0]  MaxDly  = DLY_W'(MAX_DELAY);

  always_comb begin
    if (ctrl_i[CTRL_W-1]) begin
      dly_o = '0;
    end else if (ctrl_i > MaxCtrl) begin
      dly_o = MaxDly;
    end else begin
      dly_o = ctrl_i[DLY_W-1:0];
    end
  end

endmodule

// File: rtl/vdl_ring.sv
module vdl_ring #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 481,
  parameter int AW     = 9,
  parameter int FW     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [AW-1:0]     wptr_o,
  output logic [FW-1:0]     fill_o
);

  localparam logic [AW-1:0] LastAddr = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FullCnt  = FW'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q;
  logic [FW-1:0]     fill_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (wr_en_i) begin
      wptr_q <= (wptr_q == LastAddr) ? '0 : wptr_q + 1'b1;
      if (fill_q != FullCnt) fill_q <= fill_q + 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign wptr_o    = wptr_q;
  assign fill_o    = fill_q;

endmodule

// File: rtl/vdl_tap_seq.sv
module vdl_tap_seq import vdl_pkg::*; #(
  parameter int NUM_TAPS = 2,
  parameter int TW       = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [TW-1:0] idx_o,
  output logic          done_o
);

  localparam logic [TW-1:0] LastIdx = TW'(NUM_TAPS - 1);

  seq_state_e    state_q;
  logic [TW-1:0] idx_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_RUN;
            idx_q   <= '0;
          end
        end
        SEQ_RUN: begin
          if (idx_q == LastIdx) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SEQ_RUN);
  assign idx_o  = idx_q;
  assign done_o = done_q;

endmodule

// File: rtl/vdl_multitap.sv
module vdl_multitap import vdl_pkg::*; #(
  parameter int DATA_W    = 24,
  parameter int CTRL_W    = 28,
  parameter int MAX_DELAY = 480,
  parameter int NUM_TAPS  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sample_valid_i,
  input  logic [DATA_W-1:0]            sample_i,
  input  logic [NUM_TAPS*CTRL_W-1:0]   tap_delay_i,
  output logic [NUM_TAPS*DATA_W-1:0]   tap_sample_o,
  output logic                         tap_valid_o
);

  localparam int DEPTH = MAX_DELAY + 1;
  localparam int AW    = idx_width(DEPTH);
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int TW    = idx_width(NUM_TAPS);

  logic              busy;
  logic              accept;
  logic [TW-1:0]     tap_idx;
  logic              seq_done;
  logic [AW-1:0]     wptr;
  logic [FW-1:0]     fill;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;

  logic [AW-1:0]     dly_in [NUM_TAPS];
  logic [AW-1:0]     dly_q  [NUM_TAPS];
  logic [AW-1:0]     base_q;
  logic [FW-1:0]     fill_q;
  logic [DATA_W-1:0] out_q  [NUM_TAPS];
  logic [AW-1:0]     cur_d;
  logic [DATA_W-1:0] tap_val;

  assign accept = sample_valid_i & ~busy;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    vdl_clamp #(
      .CTRL_W   (CTRL_W),
      .MAX_DELAY(MAX_DELAY),
      .DLY_W    (AW)
    ) u_clamp (
      .ctrl_i(tap_delay_i[k*CTRL_W +: CTRL_W]),
      .dly_o (dly_in[k])
    );
    assign tap_sample_o[k*DATA_W +: DATA_W] = out_q[k];
  end

  vdl_ring #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .AW    (AW),
    .FW    (FW)
  ) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (accept),
    .wr_data_i(sample_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .wptr_o   (wptr),
    .fill_o   (fill)
  );

  vdl_tap_seq #(
    .NUM_TAPS(NUM_TAPS),
    .TW      (TW)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .busy_o (busy),
    .idx_o  (tap_idx),
    .done_o (seq_done)
  );

  // controls, write slot and pre-write fill are frozen at the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      fill_q <= '0;
      for (int k = 0; k < NUM_TAPS; k++) dly_q[k] <= '0;
    end else if (accept) begin
      base_q <= wptr;
      fill_q <= fill;
      for (int k = 0; k < NUM_TAPS; k++) dly_q[k] <= dly_in[k];
    end
  end

  always_comb begin
    cur_d = dly_q[tap_idx];
    if (base_q >= cur_d) begin
      rd_addr = base_q - cur_d;
    end else begin
      rd_addr = AW'({1'b0, base_q} + (AW+1)'(DEPTH) - {1'b0, cur_d});
    end
    // reaching past the first write since reset yields silence
    tap_val = (FW'(cur_d) > fill_q) ? '0 : rd_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_TAPS; k++) out_q[k] <= '0;
    end else if (busy) begin
      out_q[tap_idx] <= tap_val;
    end
  end

  assign tap_valid_o = seq_done;

endmodule

// File: rtl/vdl_multitap_chk.sv
module vdl_multitap_chk #(
  parameter int DATA_W   = 24,
  parameter int CTRL_W   = 28,
  parameter int NUM_TAPS = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sample_valid_i,
  input logic [NUM_TAPS*CTRL_W-1:0] tap_delay_i,
  input logic [NUM_TAPS*DATA_W-1:0] tap_sample_o,
  input logic                       tap_valid_o
);

  localparam int PW = $clog2(NUM_TAPS + 1) + 1;

  logic [PW-1:0] pend_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      seen_q <= 1'b0;
    end else if (pend_q != '0) begin
      pend_q <= pend_q - 1'b1;
    end else if (sample_valid_i) begin
      pend_q <= PW'(NUM_TAPS);
      seen_q <= 1'b1;
    end
  end

  p_valid_due_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == PW'(1)) |=> tap_valid_o);

  p_valid_only_due_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_o |-> ($past(pend_q) == PW'(1)));

  p_valid_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_o |=> !tap_valid_o);

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |=> $stable(tap_sample_o));

  p_zero_before_use_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (tap_sample_o == '0));

  logic unused_ok;
  assign unused_ok = ^tap_delay_i;

endmodule

bind vdl_multitap vdl_multitap_chk #(
  .DATA_W  (DATA_W),
  .CTRL_W  (CTRL_W),
  .NUM_TAPS(NUM_TAPS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .tap_delay_i   (tap_delay_i),
  .tap_sample_o  (tap_sample_o),
  .tap_valid_o   (tap_valid_o)
);

// File: tb/tb_vdl_multitap.sv
module tb_vdl_multitap;

  localparam int DW  = 24;
  localparam int CW  = 28;
  localparam int MAX = 13;
  localparam int NT  = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sample_valid_i = 1'b0;
  logic [DW-1:0]    sample_i = '0;
  logic [NT*CW-1:0] tap_delay_i = '0;
  logic [NT*DW-1:0] tap_sample_o;
  logic             tap_valid_o;

  int checks = 0;
  int failures = 0;
  int hist[$];
  int ctl[NT];

  always #5 clk_i = ~clk_i;

  vdl_multitap #(
    .DATA_W(DW), .CTRL_W(CW), .MAX_DELAY(MAX), .NUM_TAPS(NT)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_valid_i(sample_valid_i),
    .sample_i(sample_i), .tap_delay_i(tap_delay_i),
    .tap_sample_o(tap_sample_o), .tap_valid_o(tap_valid_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tap_out(input int k);
    logic signed [DW-1:0] v;
    v = tap_sample_o[k*DW +: DW];
    return int'(v);
  endfunction

  function automatic int clampd(input int c);
    if (c < 0) return 0;
    if (c > MAX) return MAX;
    return c;
  endfunction

  function automatic int model(input int c);
    int d = clampd(c);
    if (d >= hist.size()) return 0;
    return hist[hist.size() - 1 - d];
  endfunction

  // one sample through the block, checked on every clock of the readout
  task automatic send(input int s, input string req);
    int exp[NT];
    int held[NT];
    @(negedge clk_i);
    sample_i = DW'(s);
    for (int k = 0; k < NT; k++) tap_delay_i[k*CW +: CW] = CW'(ctl[k]);
    sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    begin
      logic signed [DW-1:0] sv = DW'(s);
      hist.push_back(int'(sv));
    end
    for (int k = 0; k < NT; k++) exp[k] = model(ctl[k]);
    for (int i = 1; i < NT; i++) begin
      @(negedge clk_i);
      chk("R7", "valid early", int'(tap_valid_o), 0);
    end
    @(negedge clk_i);
    chk("R7", "valid due", int'(tap_valid_o), 1);
    for (int k = 0; k < NT; k++) begin
      chk(req, $sformatf("tap%0d ctl=%0d", k, ctl[k]), tap_out(k), exp[k]);
      held[k] = tap_out(k);
    end
    @(negedge clk_i);
    chk("R7", "valid width", int'(tap_valid_o), 0);
    for (int k = 0; k < NT; k++) chk("R8", "hold", tap_out(k), held[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < NT; k++) chk("R8", "reset out", tap_out(k), 0);
    chk("R8", "reset valid", int'(tap_valid_o), 0);

    // R2 bypass and R6 unwritten slots
    ctl[0] = 0; ctl[1] = 5; ctl[2] = MAX;
    send(111, "R6");
    send(-222, "R2");
    send(333, "R6");

    // R1 / R3 constant delays over a ramp past the wrap
    ctl[0] = 1; ctl[1] = 7; ctl[2] = MAX;
    for (int i = 0; i < 3 * (MAX + 1); i++) send(1000 + i * 3, "R3");

    // R4 clamps
    ctl[0] = 1000; ctl[1] = -5; ctl[2] = (1 << (CW - 1)) - 1;
    for (int i = 0; i < 4; i++) send(-50 - i, "R4");
    ctl[0] = -(1 << (CW - 1)); ctl[1] = MAX + 1; ctl[2] = 0;
    for (int i = 0; i < 4; i++) send(70 + i, "R4");

    // R5 independent per-sample sweeps
    for (int i = 0; i < 40; i++) begin
      ctl[0] = i % (MAX + 1);
      ctl[1] = MAX - (i % (MAX + 1));
      ctl[2] = (i * 5) % (MAX + 1);
      send(i * 17 - 300, "R5");
    end

    // R1 random controls, some out of range
    for (int i = 0; i < 60; i++) begin
      for (int k = 0; k < NT; k++) ctl[k] = int'($urandom_range(MAX + 6)) - 3;
      send(int'($urandom_range(16000000)) - 8000000, "R1");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule